// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Master

This block is a serial master that talks to a peripheral over three wires: an active-low chip select, a serial clock and one shared data line. The data line carries master output during command bytes and is released to the peripheral for response bytes. Because one wire serves both directions, the block never drives and samples the line in the same bit time. It controls the line's output enable itself, and turns the line around once per frame, between the last write byte and the first read byte.

A host starts a frame with a one-cycle `start` pulse and supplies a write byte count and a read byte count. Write bytes are taken from `wr_data` one at a time. A `wr_take` pulse marks the cycle in which a byte was captured, so the host can present the next one. Read bytes appear on `rd_data` with a one-cycle `rd_valid` pulse. All bytes travel most significant bit first. The clock idles low and input is sampled on the rising clock edge. The clock low and high times are parameters counted in system clock cycles: 20 and 22 by default, which is about a 10.5 µs bit period from a 4 MHz clock. `done` pulses when chip select returns high.

Top module: `twspi_master`

## Requirements
- R1: During and after reset: `cs_n`=1, `sclk`=0, `sdio_oe`=1, `busy`=0, and `done`, `rd_valid`, `wr_take` are 0.
- R2: During every bit of a write byte, `sdio_oe`=1 and `sdio_o` holds that byte's bit, most significant first, for the whole low and high time of the bit. `wr_take` is high for exactly the first cycle of each write byte.
- R3: Every bit consists of exactly LOW_CYC cycles with `sclk`=0 followed by exactly HIGH_CYC cycles with `sclk`=1. `sclk` is never 1 while `cs_n` is 1.
- R4: `cs_n` falls in the cycle after the edge that accepts `start`, and the first rising `sclk` comes LOW_CYC cycles later. After the final falling `sclk`, `cs_n` stays low for LOW_CYC more cycles before rising.
- R5: `sdio_oe` falls to 0 in the first low cycle of the first read byte. It stays 0 until `cs_n` rises and returns to 1 in that same cycle. It is never 0 while `cs_n` is 1.
- R6: Read bytes are built from `sdio_i` sampled at each rising `sclk` edge, most significant bit first. Each byte is presented on `rd_data` with `rd_valid` high for one cycle, in the cycle in which `sclk` falls after that byte's eighth bit.
- R7: `busy` is 1 from the cycle `cs_n` falls up to and including the last cycle `cs_n` is low. `done` is high for one cycle, the cycle in which `cs_n` returns to 1.
- R8: A `start` pulse while `busy`=1 is ignored: the frame in progress continues unchanged.
- R9: A `start` with both counts zero produces a `done` pulse in the next cycle, with no chip select, clock or output-enable activity.
- R10: A frame carries all `wr_len` write bytes first, then all `rd_len` read bytes, with no gap between bytes beyond the normal bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled only when idle) |
| wr_len | input | CNT_W | Number of write bytes in the frame |
| rd_len | input | CNT_W | Number of read bytes in the frame |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Pulse: write byte captured, present the next |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Pulse: frame finished, chip select released |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, output enable (1 = master drives) |
| sdio_i | input | 1 | Shared data line, sensed value |

## Verification
The bench builds the block with LOW_CYC=3, HIGH_CYC=2 and CNT_W=4. The unequal low and high times make an exchange of the two counters visible. The short bit period allows frames that are write-only, read-only and mixed, each with several bytes and different patterns, within a few thousand cycles. With four-bit counts, a frame of both counts zero and a start pulse issued in the middle of a frame can also be exercised. The reference model checks every cycle of every frame, including the turnaround cycle and the trailing chip-select hold.

// File: rtl/twspi_pkg.sv
package twspi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_e;

    typedef enum logic {
        DIR_WRITE,
        DIR_READ
    } dir_e;

    function automatic int phase_len(phase_e ph, int low_cyc, int high_cyc);
        return (ph == PH_HIGH) ? high_cyc : low_cyc;
    endfunction

endpackage

// File: rtl/twspi_phase_timer.sv
module twspi_phase_timer
    import twspi_pkg::*;
#(
    parameter int LOW_CYC  = 20,
    parameter int HIGH_CYC = 22
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    output logic   last
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    int            len;

    always_comb begin
        len  = phase_len(phase, LOW_CYC, HIGH_CYC);
        last = (phase != PH_IDLE) && (cnt == CW'(len - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || phase == PH_IDLE || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (int'(cnt) < len));

endmodule

// File: rtl/twspi_shifter.sv
module twspi_shifter
    import twspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shl_out,
    input  logic              shl_in,
    input  logic              din,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shl_in) begin
            q <= {q[BYTE_W-2:0], din};
        end else if (shl_out) begin
            q <= {q[BYTE_W-2:0], 1'b0};
        end
    end

    // R6
    no_dual_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !(shl_in && shl_out));

endmodule

// File: rtl/twspi_master.sv
module twspi_master
    import twspi_pkg::*;
#(
    parameter int LOW_CYC  = 20,
    parameter int HIGH_CYC = 22,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  rd_len,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_take,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sdio_i
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(BYTE_W - 1);

    phase_e            phase;
    dir_e              dir;
    logic [BIT_W-1:0]  bit_idx;
    logic [CNT_W-1:0]  wr_left;
    logic [CNT_W-1:0]  rd_left;
    logic              tick_last;
    logic              byte_end;
    logic              ld_first;
    logic              ld_next;
    logic              sh_load;
    logic              sh_out;
    logic              sh_in;
    logic [BYTE_W-1:0] sreg;

    twspi_phase_timer #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (tick_last)
    );

    always_comb begin
        byte_end = (phase == PH_HIGH) && tick_last && (bit_idx == '0);
        ld_first = (phase == PH_IDLE) && start && (wr_len != '0);
        ld_next  = byte_end && (wr_left != '0);
        sh_load  = ld_first || ld_next;
        sh_out   = (phase == PH_HIGH) && tick_last && (bit_idx != '0) && (dir == DIR_WRITE);
        sh_in    = (phase == PH_LOW) && tick_last && (dir == DIR_READ);
    end

    twspi_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (wr_data),
        .shl_out  (sh_out),
        .shl_in   (sh_in),
        .din      (sdio_i),
        .q        (sreg)
    );

    assign sdio_o = sreg[BYTE_W-1];
    assign busy   = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            dir      <= DIR_WRITE;
            bit_idx  <= '0;
            wr_left  <= '0;
            rd_left  <= '0;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            sdio_oe  <= 1'b1;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (wr_len == '0 && rd_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            cs_n    <= 1'b0;
                            phase   <= PH_LOW;
                            bit_idx <= MSB_IDX;
                            if (wr_len != '0) begin
                                dir     <= DIR_WRITE;
                                wr_left <= wr_len - 1'b1;
                                rd_left <= rd_len;
                                wr_take <= 1'b1;
                            end else begin
                                dir     <= DIR_READ;
                                wr_left <= '0;
                                rd_left <= rd_len - 1'b1;
                                sdio_oe <= 1'b0;
                            end
                        end
                    end
                end
                PH_LOW: begin
                    if (tick_last) begin
                        sclk  <= 1'b1;
                        phase <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick_last) begin
                        sclk <= 1'b0;
                        if (bit_idx != '0) begin
                            bit_idx <= bit_idx - 1'b1;
                            phase   <= PH_LOW;
                        end else begin
                            if (dir == DIR_READ) begin
                                rd_data  <= sreg;
                                rd_valid <= 1'b1;
                            end
                            if (wr_left != '0) begin
                                wr_left <= wr_left - 1'b1;
                                wr_take <= 1'b1;
                                dir     <= DIR_WRITE;
                                bit_idx <= MSB_IDX;
                                phase   <= PH_LOW;
                            end else if (rd_left != '0) begin
                                rd_left <= rd_left - 1'b1;
                                dir     <= DIR_READ;
                                sdio_oe <= 1'b0;
                                bit_idx <= MSB_IDX;
                                phase   <= PH_LOW;
                            end else begin
                                phase <= PH_TAIL;
                            end
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick_last) begin
                        cs_n    <= 1'b1;
                        sdio_oe <= 1'b1;
                        done    <= 1'b1;
                        phase   <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5
    oe_low_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !sdio_oe |-> !cs_n);

    // R5
    oe_return_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> $rose(cs_n));

    // R3
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R4
    cs_fall_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R7
    done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n);

    // R6
    rd_valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!cs_n && !sdio_oe));

endmodule

// File: tb/tb_twspi_master.sv
module tb_twspi_master;
    localparam int LOW  = 3;
    localparam int HIGH = 2;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [CW-1:0] wr_len, rd_len;
    logic [7:0]    wr_data;
    logic          wr_take, rd_valid, busy, done, cs_n, sclk, sdio_o, sdio_oe;
    logic [7:0]    rd_data;
    logic          sdio_i;

    always #4 clk = ~clk;

    twspi_master #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .start(start), .wr_len(wr_len), .rd_len(rd_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    typedef struct {
        bit cs_n; bit sclk; bit oe; bit sdo_chk; bit sdo;
        bit wt; bit rv; bit done; bit busy;
    } exp_t;

    exp_t       eq[$];
    logic [7:0] rexp[$];
    logic [7:0] hostq[$];
    logic [7:0] slave[$];
    int         rise_cnt;
    bit         prev_sclk;
    int         n_cmp = 0;
    int         n_bad = 0;

    function automatic exp_t idle_e();
        exp_t e;
        e.cs_n = 1; e.sclk = 0; e.oe = 1; e.sdo_chk = 0; e.sdo = 0;
        e.wt = 0; e.rv = 0; e.done = 0; e.busy = 0;
        return e;
    endfunction

    function automatic void build(int nw, int nr, logic [7:0] wb[$], logic [7:0] rb[$]);
        exp_t e;
        bit   pend = 0;
        if (nw == 0 && nr == 0) begin
            e = idle_e(); e.done = 1; eq.push_back(e);
            return;
        end
        for (int b = 0; b < nw + nr; b++) begin
            bit rd = (b >= nw);
            logic [7:0] v = rd ? 8'h00 : wb[b];
            if (rd) rexp.push_back(rb[b - nw]);
            for (int i = 7; i >= 0; i--) begin
                for (int c = 0; c < LOW + HIGH; c++) begin
                    e = idle_e();
                    e.cs_n = 0; e.busy = 1; e.oe = !rd;
                    e.sclk = (c >= LOW);
                    e.sdo_chk = !rd; e.sdo = v[i];
                    e.wt = !rd && i == 7 && c == 0;
                    e.rv = pend && i == 7 && c == 0;
                    eq.push_back(e);
                end
            end
            pend = rd;
        end
        for (int c = 0; c < LOW; c++) begin
            e = idle_e();
            e.cs_n = 0; e.busy = 1; e.oe = (nr == 0);
            e.rv = pend && c == 0;
            eq.push_back(e);
        end
        e = idle_e(); e.done = 1; eq.push_back(e);
    endfunction

    task automatic fail(string req, string what, int act, int exp);
        $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    endtask

    task automatic tick();
        exp_t e;
        bit   bad = 0;
        @(negedge clk);
        e = (eq.size() > 0) ? eq.pop_front() : idle_e();
        if (rst) e = idle_e(); // R1 reset state
        if (cs_n !== e.cs_n) begin bad = 1; fail("R4", "cs_n", cs_n, e.cs_n); end
        if (sclk !== e.sclk) begin bad = 1; fail("R3", "sclk", sclk, e.sclk); end
        if (sdio_oe !== e.oe) begin bad = 1; fail("R5", "sdio_oe", sdio_oe, e.oe); end
        if (e.sdo_chk && sdio_o !== e.sdo) begin bad = 1; fail("R2", "sdio_o", sdio_o, e.sdo); end
        if (wr_take !== e.wt) begin bad = 1; fail("R2", "wr_take", wr_take, e.wt); end
        if (rd_valid !== e.rv) begin bad = 1; fail("R6", "rd_valid", rd_valid, e.rv); end
        if (done !== e.done) begin bad = 1; fail("R7", "done", done, e.done); end
        if (busy !== e.busy) begin bad = 1; fail("R7", "busy", busy, e.busy); end
        n_cmp++;
        if (bad) n_bad++;
        if (rd_valid === 1'b1) begin
            n_cmp++;
            if (rexp.size() == 0) begin
                n_bad++; fail("R6", "unexpected rd_data", rd_data, -1);
            end else begin
                logic [7:0] x = rexp.pop_front();
                if (rd_data !== x) begin n_bad++; fail("R6", "rd_data", rd_data, x); end
            end
        end
        // host side: present the next write byte after a capture (R10 ordering)
        if (wr_take === 1'b1 && hostq.size() > 0) wr_data = hostq.pop_front();
        // peripheral side: drives bits MSB first, advancing after each rising clock
        if (cs_n === 1'b1) rise_cnt = 0;
        else if (!sdio_oe && sclk && !prev_sclk) rise_cnt++;
        prev_sclk = sclk;
        if (rise_cnt / 8 < slave.size()) sdio_i = slave[rise_cnt / 8][7 - (rise_cnt % 8)];
        else sdio_i = 1'b1;
    endtask

    task automatic run_txn(int nw, int nr, logic [7:0] wb[$], logic [7:0] rb[$], int poke_at);
        hostq = wb;
        if (nw > 0) wr_data = hostq.pop_front();
        slave = rb;
        rise_cnt = 0;
        build(nw, nr, wb, rb);
        start = 1; wr_len = CW'(nw); rd_len = CW'(nr);
        tick();
        start = 0; wr_len = '0; rd_len = '0;
        for (int k = 1; eq.size() > 0; k++) begin
            if (k == poke_at) begin
                start = 1; wr_len = 4'd2; rd_len = 4'd1; // R8 ignored while busy
            end
            tick();
            start = 0; wr_len = '0; rd_len = '0;
        end
        for (int k = 0; k < 4; k++) tick();
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; start = 0; wr_len = '0; rd_len = '0; wr_data = '0; sdio_i = 1'b1;
        prev_sclk = 0; rise_cnt = 0;
        for (int k = 0; k < 4; k++) tick();   // R1 during reset
        rst = 0;
        for (int k = 0; k < 3; k++) tick();   // R1 after reset
        // R2 R3 R4: write-only frame, two bytes
        run_txn(2, 0, '{8'hA5, 8'h3C}, '{}, 0);
        // R5 R6: read-only frame, two bytes
        run_txn(0, 2, '{}, '{8'hC3, 8'h01}, 0);
        // R10 R5: one write then three reads
        run_txn(1, 3, '{8'h80}, '{8'hFF, 8'h00, 8'h96}, 0);
        // R9: both counts zero
        run_txn(0, 0, '{}, '{}, 0);
        // R8: start pulse mid-frame
        run_txn(2, 1, '{8'h5A, 8'hE7}, '{8'h42}, 30);
        // R10: three writes, one read
        run_txn(3, 1, '{8'h01, 8'hFE, 8'h7F}, '{8'h81}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule